// File: doc/BRIEF.md
# Serial Management Bus Master

This block is a master for the two-wire serial management bus used to reach the internal registers of an Ethernet PHY. A single request strobe, together with a read/write flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data, starts one complete frame. The block produces the management clock and the outgoing data bit, samples the incoming data bit, and drives a direction output that tells the pad logic whether the host or the PHY owns the shared data wire.

A frame opens with a preamble of 32 clock periods with the line held high. The header follows it. On a write the master keeps the line and sends a fixed turnaround code and the data word. On a read it releases the line between clock pulses, checks the slot after the turnaround for an error, and shifts in the 16-bit register value. When the frame ends, a one-cycle done pulse reports the read value and the error flag. A runtime half-period input sets the management clock rate relative to the system clock. Its value is latched when a request is accepted.

Top module: `mdio_master`

## Requirements
- R1: While reset is asserted and after it is released, mdc is 0, mdo is 1, md_oe is 1 (host drives), busy and done are 0, and rd_data and rd_err are 0.
- R2: For the first 32 rising edges of mdc after a request is accepted, mdo is 1 and md_oe is 1.
- R3: Rising edges 33 to 46 carry, MSB first, the start code 01, then the opcode (10 for a read, 01 for a write), then req_phy[4:0], then req_reg[4:0].
- R4: mdo changes only while mdc is low. It is constant on every cycle in which mdc is high, including the cycle in which mdc rises.
- R5: On a write, rising edges 47 and 48 carry the turnaround bits 1 then 0, and edges 49 to 64 carry req_wdata MSB first. md_oe stays 1 for the whole frame. The done pulse reports rd_data = 0 and rd_err = 0.
- R6: Every frame has exactly 64 rising edges of mdc. On a read, md_oe drops to 0 after the fall that ends edge 46 and before edge 47, and it stays 0 through edge 64. md_oe changes only while mdc is low. It is 1 again when done pulses.
- R7: On a read, mdi is sampled on the system clock edge at which mdc makes its 48th rise. A 1 there sets rd_err and forces rd_data to 0, while all 64 edges are still generated.
- R8: On a read without error, mdi is sampled at the system clock edges where mdc makes rises 49 to 64, and these samples form rd_data MSB first.
- R9: Each low phase and each high phase of mdc lasts H system clocks. H is half_cycles as latched at acceptance, or DEF_HALF when that value is 0. done pulses exactly 128*H clocks after the acceptance edge.
- R10: A request is accepted when req is 1 and busy is 0. busy is 1 from the cycle after acceptance until done. done is a single-cycle pulse during which busy is 0. A request made while busy is ignored, including its fields and half_cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, taken when not busy |
| req_rd | input | 1 | 1 = read frame, 0 = write frame |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Data for a write frame |
| half_cycles | input | DIV_W | System clocks per mdc phase; 0 selects DEF_HALF |
| mdi | input | 1 | Data bit from the shared line |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Data bit toward the shared line |
| md_oe | output | 1 | 1 = host owns the data line, 0 = PHY owns it |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Register value of the last read, 0 after a write or an error |
| rd_err | output | 1 | Error flag of the last read |

## Verification
The embedded assertions watch, on every cycle, that mdo holds still while mdc is high, that the direction output moves only while mdc is low and only inside a frame, that done is a lone pulse outside busy, and that an error completion returns zero data. The directed scenarios are needed for what only a whole frame can show: the count of 64 edges, the bit order of the preamble, header, turnaround and data, the slot where the direction flips, where the error bit and each data bit are picked up, the exact frame length for several divider settings, and that a request made during a frame leaves it untouched.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_SLOTS   = 32;
    localparam int FRAME_BITS  = 32;
    localparam int TOTAL_SLOTS = PRE_SLOTS + FRAME_BITS;
    localparam int SLOT_W      = $clog2(TOTAL_SLOTS);
    localparam int LAST_SLOT   = TOTAL_SLOTS - 1;
    localparam int HDR_BITS    = 14;
    localparam int TURN_SLOT   = PRE_SLOTS + HDR_BITS;
    localparam int ERR_SLOT    = TURN_SLOT + 1;
    localparam int DATA_SLOT0  = TURN_SLOT + 2;
    localparam int DATA_W      = 16;

    localparam logic [1:0] CODE_START = 2'b01;
    localparam logic [1:0] CODE_RD    = 2'b10;
    localparam logic [1:0] CODE_WR    = 2'b01;
    localparam logic [1:0] CODE_TURN  = 2'b10;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } mdc_phase_e;

    typedef struct packed {
        logic              rd;
        logic [4:0]        phy;
        logic [4:0]        regad;
        logic [DATA_W-1:0] wdata;
    } mdio_req_t;

    // Outgoing frame after the preamble; the read tail is all ones (line released).
    function automatic logic [FRAME_BITS-1:0] frame_word(input mdio_req_t r);
        if (r.rd)
            return {CODE_START, CODE_RD, r.phy, r.regad, {(DATA_W + 2){1'b1}}};
        else
            return {CODE_START, CODE_WR, r.phy, r.regad, CODE_TURN, r.wdata};
    endfunction

endpackage

// File: rtl/mdio_phase_gen.sv
module mdio_phase_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = active && (cnt == half - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !active || tick)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt < half));

endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift import mdio_pkg::*; (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] word,
    input  logic                  shift,
    output logic                  bit_out
);
    logic [FRAME_BITS-1:0] sr;

    assign bit_out = sr[FRAME_BITS-1];

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '1;
        else if (load)
            sr <= word;
        else if (shift)
            sr <= {sr[FRAME_BITS-2:0], 1'b1};
    end

endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture import mdio_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              cap_err,
    input  logic              cap_bit,
    input  logic              mdi,
    output logic              err,
    output logic [DATA_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            err  <= 1'b0;
            word <= '0;
        end else begin
            if (cap_err)
                err <= mdi;
            if (cap_bit)
                word <= {word[DATA_W-2:0], mdi};
        end
    end

    // R7
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> !err);

endmodule

// File: rtl/mdio_master.sv
module mdio_master import mdio_pkg::*; #(
    parameter int DIV_W    = 8,
    parameter int DEF_HALF = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_rd,
    input  logic [4:0]        req_phy,
    input  logic [4:0]        req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DIV_W-1:0]  half_cycles,
    input  logic              mdi,
    output logic              mdc,
    output logic              mdo,
    output logic              md_oe,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err
);
    localparam logic [DIV_W-1:0]  DEF_H    = DIV_W'(DEF_HALF);
    localparam logic [SLOT_W-1:0] S_LAST   = SLOT_W'(LAST_SLOT);
    localparam logic [SLOT_W-1:0] S_PRE_M1 = SLOT_W'(PRE_SLOTS - 1);
    localparam logic [SLOT_W-1:0] S_TURN   = SLOT_W'(TURN_SLOT);
    localparam logic [SLOT_W-1:0] S_ERR    = SLOT_W'(ERR_SLOT);
    localparam logic [SLOT_W-1:0] S_DATA0  = SLOT_W'(DATA_SLOT0);

    mdc_phase_e            state;
    logic [SLOT_W-1:0]     slot;
    logic [DIV_W-1:0]      half_q;
    logic                  rd_q;
    logic                  mdo_q;
    logic                  oe_q;
    logic                  done_q;
    logic [DATA_W-1:0]     rdata_q;
    logic                  err_q;

    logic                  tick;
    logic                  accept;
    logic                  rise_tick;
    logic                  fall_tick;
    logic                  last_fall;
    logic                  tx_shift;
    logic                  tx_bit;
    logic                  cap_err;
    logic                  cap_bit;
    logic                  rx_err;
    logic [DATA_W-1:0]     rx_word;
    mdio_req_t             req_s;
    logic [FRAME_BITS-1:0] tx_word;

    assign req_s     = '{rd: req_rd, phy: req_phy, regad: req_reg, wdata: req_wdata};
    assign tx_word   = frame_word(req_s);
    assign accept    = req && (state == PH_IDLE);
    assign rise_tick = (state == PH_LOW) && tick;
    assign fall_tick = (state == PH_HIGH) && tick;
    assign last_fall = fall_tick && (slot == S_LAST);
    assign tx_shift  = fall_tick && !last_fall && (slot >= S_PRE_M1);
    assign cap_err   = rise_tick && rd_q && (slot == S_ERR);
    assign cap_bit   = rise_tick && rd_q && (slot >= S_DATA0);

    mdio_phase_gen #(.DIV_W(DIV_W)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .active (state != PH_IDLE),
        .half   (half_q),
        .tick   (tick)
    );

    mdio_tx_shift u_tx (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .word    (tx_word),
        .shift   (tx_shift),
        .bit_out (tx_bit)
    );

    mdio_rx_capture u_rx (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .cap_err (cap_err),
        .cap_bit (cap_bit),
        .mdi     (mdi),
        .err     (rx_err),
        .word    (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PH_IDLE;
            slot    <= '0;
            half_q  <= DEF_H;
            rd_q    <= 1'b0;
            mdo_q   <= 1'b1;
            oe_q    <= 1'b1;
            done_q  <= 1'b0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                PH_IDLE: begin
                    if (accept) begin
                        state  <= PH_LOW;
                        slot   <= '0;
                        rd_q   <= req_rd;
                        mdo_q  <= 1'b1;
                        oe_q   <= 1'b1;
                        half_q <= (half_cycles == '0) ? DEF_H : half_cycles;
                    end
                end
                PH_LOW: begin
                    if (tick)
                        state <= PH_HIGH;
                end
                PH_HIGH: begin
                    if (last_fall) begin
                        state   <= PH_IDLE;
                        mdo_q   <= 1'b1;
                        oe_q    <= 1'b1;
                        done_q  <= 1'b1;
                        rdata_q <= (rd_q && !rx_err) ? rx_word : '0;
                        err_q   <= rd_q && rx_err;
                    end else if (tick) begin
                        state <= PH_LOW;
                        slot  <= slot + SLOT_W'(1);
                        if (slot >= S_PRE_M1)
                            mdo_q <= tx_bit;
                        if (rd_q && (slot + SLOT_W'(1) == S_TURN))
                            oe_q <= 1'b0;
                    end
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

    assign mdc     = (state == PH_HIGH);
    assign mdo     = mdo_q;
    assign md_oe   = oe_q;
    assign busy    = (state != PH_IDLE);
    assign done    = done_q;
    assign rd_data = rdata_q;
    assign rd_err  = err_q;

    // R4
    mdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mdc |-> $stable(mdo));

    // R6
    oe_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(md_oe) |-> !mdc);

    // R6
    oe_inside_chk: assert property (@(posedge clk) disable iff (rst)
        !md_oe |-> busy);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R7
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && rd_err) |-> (rd_data == '0));

    // R1
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && md_oe));

endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_rd = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic [7:0]  half_cycles = 8'd2;
    logic        mdi = 1'b1;
    logic        mdc, mdo, md_oe, busy, done, rd_err;
    logic [15:0] rd_data;

    always #10 clk = ~clk;

    mdio_master #(.DIV_W(8), .DEF_HALF(10)) u_mdio_master (
        .clk(clk), .rst(rst), .req(req), .req_rd(req_rd), .req_phy(req_phy),
        .req_reg(req_reg), .req_wdata(req_wdata), .half_cycles(half_cycles),
        .mdi(mdi), .mdc(mdc), .mdo(mdo), .md_oe(md_oe), .busy(busy),
        .done(done), .rd_data(rd_data), .rd_err(rd_err)
    );

    int total = 0;
    int bad = 0;

    // PHY model and line monitor
    logic        mdc_prev = 1'b0;
    logic        busy_prev = 1'b0;
    int          rise_cnt = 0;
    int          cyc = 0;
    int          start_cyc = 0;
    int          done_cyc = 0;
    int          done_hi = 0;
    logic        mdo_at [1:64];
    logic        oe_at  [1:64];
    logic        phy_err = 1'b0;
    logic [15:0] phy_data = '0;

    always @(negedge clk) begin
        cyc++;
        if (busy && !busy_prev) begin
            rise_cnt  = 0;
            start_cyc = cyc;
            done_hi   = 0;
        end
        if (done) begin
            done_cyc = cyc;
            done_hi++;
        end
        if (mdc && !mdc_prev) begin
            rise_cnt++;
            if (rise_cnt <= 64) begin
                mdo_at[rise_cnt] = mdo;
                oe_at[rise_cnt]  = md_oe;
            end
            if (rise_cnt == 47)
                mdi = phy_err;
            else if (rise_cnt >= 48 && rise_cnt <= 63)
                mdi = phy_data[63 - rise_cnt];
            else
                mdi = 1'b1;
        end
        mdc_prev  = mdc;
        busy_prev = busy;
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_reset();
        chk(mdc == 1'b0 && mdo == 1'b1 && md_oe == 1'b1, "R1 line idle",
            {29'd0, mdc, mdo, md_oe}, 32'h3);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done",
            {30'd0, busy, done}, 32'h0);
        chk(rd_data == 16'h0 && rd_err == 1'b0, "R1 read result",
            {15'd0, rd_err, rd_data}, 32'h0);
    endtask

    task automatic run_txn(input bit rd, input logic [4:0] phy, input logic [4:0] regad,
                           input logic [15:0] wdata, input logic [7:0] half,
                           input bit perr, input logic [15:0] pdata, input bit intrude);
        int eh;
        logic [13:0] hdr_got, hdr_exp;
        logic [15:0] dat_got;
        bit ok;
        eh = (half == 8'd0) ? 10 : int'(half);
        @(negedge clk);
        req_rd = rd; req_phy = phy; req_reg = regad; req_wdata = wdata;
        half_cycles = half; phy_err = perr; phy_data = pdata;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", {31'd0, busy}, 32'h1);
        if (intrude) begin
            repeat (20) @(negedge clk);
            req_rd = !rd; req_phy = ~phy; req_reg = ~regad; req_wdata = ~wdata;
            half_cycles = half + 8'd1;
            req = 1'b1;
            @(negedge clk);
            req = 1'b0;
        end
        do @(negedge clk); while (done !== 1'b1);
        @(negedge clk);

        chk(rise_cnt == 64, "R6 edge count", rise_cnt, 64);
        ok = 1;
        for (int i = 1; i <= 32; i++)
            if (mdo_at[i] !== 1'b1 || oe_at[i] !== 1'b1) ok = 0;
        chk(ok, "R2 preamble", {31'd0, ok}, 32'h1);

        hdr_exp = {2'b01, (rd ? 2'b10 : 2'b01), phy, regad};
        hdr_got = '0;
        for (int i = 0; i < 14; i++) hdr_got = {hdr_got[12:0], mdo_at[33 + i]};
        chk(hdr_got == hdr_exp, "R3 header", {18'd0, hdr_got}, {18'd0, hdr_exp});

        if (!rd) begin
            chk({mdo_at[47], mdo_at[48]} == 2'b10, "R5 turnaround",
                {30'd0, mdo_at[47], mdo_at[48]}, 32'h2);
            dat_got = '0;
            for (int i = 0; i < 16; i++) dat_got = {dat_got[14:0], mdo_at[49 + i]};
            chk(dat_got == wdata, "R5 write data", {16'd0, dat_got}, {16'd0, wdata});
            ok = 1;
            for (int i = 33; i <= 64; i++) if (oe_at[i] !== 1'b1) ok = 0;
            chk(ok, "R5 host keeps line", {31'd0, ok}, 32'h1);
            chk(rd_data == 16'h0 && rd_err == 1'b0, "R5 write result",
                {15'd0, rd_err, rd_data}, 32'h0);
        end else begin
            ok = (oe_at[46] === 1'b1);
            for (int i = 47; i <= 64; i++) if (oe_at[i] !== 1'b0) ok = 0;
            chk(ok, "R6 direction handover", {31'd0, ok}, 32'h1);
            chk(rd_err == perr, "R7 error flag", {31'd0, rd_err}, {31'd0, perr});
            if (perr)
                chk(rd_data == 16'h0, "R7 data forced to zero", {16'd0, rd_data}, 32'h0);
            else
                chk(rd_data == pdata, "R8 read data", {16'd0, rd_data}, {16'd0, pdata});
        end
        chk(md_oe == 1'b1 && mdc == 1'b0, "R6 line returned",
            {30'd0, md_oe, mdc}, 32'h2);
        chk(done_cyc - start_cyc == 128 * eh, "R9 frame length",
            done_cyc - start_cyc, 128 * eh);
        chk(done_hi == 1 && busy == 1'b0, "R10 done pulse",
            {busy, 31'(done_hi)}, 32'h1);
    endtask

    task automatic write_basic();
        run_txn(1'b0, 5'd5, 5'd3, 16'hA5C3, 8'd2, 1'b0, 16'h0, 1'b0);
    endtask

    task automatic read_basic();
        run_txn(1'b1, 5'd1, 5'd2, 16'h0, 8'd2, 1'b0, 16'h1234, 1'b0);
    endtask

    task automatic read_error();
        run_txn(1'b1, 5'd9, 5'd17, 16'h0, 8'd3, 1'b1, 16'hBEEF, 1'b0);
    endtask

    task automatic read_default_rate();
        run_txn(1'b1, 5'd31, 5'd31, 16'h0, 8'd0, 1'b0, 16'hFFFF, 1'b0);
    endtask

    task automatic write_with_intrusion();
        run_txn(1'b0, 5'd0, 5'd0, 16'h0001, 8'd1, 1'b0, 16'h0, 1'b1);
    endtask

    task automatic read_after_error();
        run_txn(1'b1, 5'd16, 5'd1, 16'h0, 8'd1, 1'b0, 16'h8001, 1'b0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_reset();
        rst = 1'b0;
        @(negedge clk);
        check_reset();
        write_basic();
        read_basic();
        read_error();
        read_default_rate();
        write_with_intrusion();
        read_after_error();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule